// File: doc/BRIEF.md
# Watchdog Timer with Pre-Reset Interrupt

A free-running counter on the raw input clock that warns software before it forces a reset. Software picks one of four power-of-two timeout lengths. When the count reaches the chosen length, a sticky warning flag is raised, and it can drive an interrupt. A fixed guard interval later, a one-cycle reset request is issued if the reset function is enabled. The counter then returns to zero and starts the next period.

Software restarts the counter, or changes whether the reset is armed, only through a short unlock window. The window opens after a two-byte key is written to an access register. Writes to the guarded bits outside the window are dropped. The other control fields are always writable: interrupt enable, timeout select and flag clear. A new timeout select takes effect at the next restart, so a period that is already running keeps its length. All access goes through a small register port. The outputs are an interrupt line and a reset-request pulse.

Top module: `wdt_timer`

## Requirements
- R1: After a restart, the warning flag (control bit 3) sets exactly 2^(BASE_SHIFT + SHIFT_STEP*sel) clocks later. Here sel is control bits 5:4 in effect at that restart, and the defaults give 2^17, 2^20, 2^23 and 2^26.
- R2: When reset is armed (control bit 1), `rst_req_o` pulses exactly WARN_GAP clocks after the flag sets (512 by default).
- R3: When reset is not armed, no reset pulse occurs. The counter still returns to zero at the reset point, so the flag sets again one full length later.
- R4: The flag stays set until software writes 1 to control bit 3. Clearing the flag does not move the counter.
- R5: `irq_o` equals the flag ANDed with the interrupt enable (control bit 2). The enable is writable at any time, and the flag sets whether or not the enable is on.
- R6: Outside the unlock window, writes to the restart bit (control bit 0) and the reset-arm bit (control bit 1) have no effect.
- R7: The window opens only after a write of 0xAA to the access register (address 1) is followed by a write of 0x55, with no other write between them. It stays open for the next OPEN_CYCLES clocks (4 by default) and then closes. Bit 0 of the access register reads 1 while the window is open.
- R8: A restart made during the guard interval, before the reset point, prevents the reset pulse.
- R9: `rst_req_o` is high for a single clock. The counter is zero after it, so the next flag sets one full length later.
- R10: Changing the select field without a restart leaves the running length unchanged. The restart write's own select value applies from that restart.
- R11: Out of reset, the control register (address 0) and the access register read 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock, counting time base |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Early-warning interrupt request |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
A fault in the counter, in the latched select or in the reset point shows at the ports as a flag or pulse that arrives early or late by a whole number of cycles. The bench samples the cycles on either side of each expected edge, so a shift of even one clock is caught within one period of the shortest configuration. A fault in the unlock sequencer shows within a few cycles: the window bit reads wrongly, or a guarded bit changes when it should not. The window is probed at its last open cycle and at its first closed cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ACC  = 2'd1;

  localparam logic [DATA_W-1:0] KEY_FIRST  = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SECOND = 8'h55;

  // control register bit positions
  localparam int unsigned BIT_RESTART = 0;
  localparam int unsigned BIT_RST_EN  = 1;
  localparam int unsigned BIT_IRQ_EN  = 2;
  localparam int unsigned BIT_FLAG    = 3;
  localparam int unsigned BIT_SEL_LO  = 4;

  typedef logic [1:0] sel_t;

  typedef struct packed {
    logic rst_en;
    logic irq_en;
    logic flag;
    sel_t sel;
  } ctrl_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
  parameter int unsigned OPEN_CYCLES = 4,
  localparam int unsigned WIN_W = $clog2(OPEN_CYCLES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       is_acc_i,
  input  logic [7:0] data_i,
  output logic       open_o
);
  import wdt_pkg::*;

  logic             armed_q;
  logic [WIN_W-1:0] win_cnt_q;
  logic             key_done;

  assign key_done = wr_i && is_acc_i && (data_i == KEY_SECOND) && armed_q;
  assign open_o   = (win_cnt_q != '0);

  // any write re-evaluates the first key, so writes in between break the pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else if (wr_i) begin
      armed_q <= is_acc_i && (data_i == KEY_FIRST);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q <= '0;
    end else if (key_done) begin
      win_cnt_q <= WIN_W'(OPEN_CYCLES);
    end else if (win_cnt_q != '0) begin
      win_cnt_q <= win_cnt_q - 1'b1;
    end
  end

  AST_WIN_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_cnt_q <= WIN_W'(OPEN_CYCLES)); // R7
  AST_KEY_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_done |=> open_o); // R7
  AST_NO_KEY_NO_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && !key_done) |=> !open_o); // R7
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned BASE_SHIFT = 17,
  parameter int unsigned SHIFT_STEP = 3,
  parameter int unsigned WARN_GAP   = 512,
  localparam int unsigned MAX_SHIFT = BASE_SHIFT + 3 * SHIFT_STEP,
  localparam int unsigned CNT_W     = MAX_SHIFT + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  wdt_pkg::sel_t    sel_i,
  input  logic             rst_en_i,
  output logic             tmo_o,
  output logic             rst_req_o
);
  import wdt_pkg::*;

  logic [CNT_W-1:0] len_tbl [4];
  logic [CNT_W-1:0] cnt_q, len, rst_pt;
  sel_t             act_sel_q;
  logic             at_rst_pt, rst_q;

  for (genvar g = 0; g < 4; g++) begin : g_len
    assign len_tbl[g] = CNT_W'(1) << (BASE_SHIFT + SHIFT_STEP * g);
  end

  assign len       = len_tbl[act_sel_q];
  assign rst_pt    = len + CNT_W'(WARN_GAP);
  assign at_rst_pt = (cnt_q == rst_pt - 1'b1);
  assign tmo_o     = !restart_i && (cnt_q == len - 1'b1);
  assign rst_req_o = rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      act_sel_q <= '0;
      rst_q     <= 1'b0;
    end else begin
      rst_q <= !restart_i && at_rst_pt && rst_en_i;
      if (restart_i) begin
        cnt_q     <= '0;
        act_sel_q <= sel_i;
      end else if (at_rst_pt) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R9
  AST_RST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(rst_en_i)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < rst_pt); // R9
  AST_SEL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> $stable(act_sel_q)); // R10
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [1:0]          addr_i,
  input  logic [7:0]          data_i,
  input  logic                win_open_i,
  input  logic                tmo_i,
  output logic                restart_o,
  output wdt_pkg::sel_t       sel_o,
  output logic                rst_en_o,
  output logic                irq_o,
  output logic [7:0]          rdata_o
);
  import wdt_pkg::*;

  ctrl_t ctrl_q;
  logic  ctrl_wr, flag_clr;

  assign ctrl_wr   = wr_i && (addr_i == ADDR_CTRL);
  assign flag_clr  = ctrl_wr && data_i[BIT_FLAG];
  assign restart_o = ctrl_wr && data_i[BIT_RESTART] && win_open_i;
  assign sel_o     = data_i[BIT_SEL_LO +: 2];
  assign rst_en_o  = ctrl_q.rst_en;
  assign irq_o     = ctrl_q.flag && ctrl_q.irq_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.irq_en <= data_i[BIT_IRQ_EN];
        ctrl_q.sel    <= data_i[BIT_SEL_LO +: 2];
        if (win_open_i) ctrl_q.rst_en <= data_i[BIT_RST_EN];
      end
      // a timeout in the same cycle wins over a clear
      if (tmo_i)         ctrl_q.flag <= 1'b1;
      else if (flag_clr) ctrl_q.flag <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[BIT_RST_EN]       = ctrl_q.rst_en;
        rdata_o[BIT_IRQ_EN]       = ctrl_q.irq_en;
        rdata_o[BIT_FLAG]         = ctrl_q.flag;
        rdata_o[BIT_SEL_LO +: 2]  = ctrl_q.sel;
      end
      ADDR_ACC: rdata_o[0] = win_open_i;
      default:  rdata_o = '0;
    endcase
  end

  AST_RSTEN_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_open_i |=> $stable(ctrl_q.rst_en)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.flag && !flag_clr) |=> ctrl_q.flag); // R4
  AST_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> ctrl_q.flag); // R1
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int unsigned BASE_SHIFT  = 17,
  parameter int unsigned SHIFT_STEP  = 3,
  parameter int unsigned WARN_GAP    = 512,
  parameter int unsigned OPEN_CYCLES = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  import wdt_pkg::*;

  logic win_open, restart, rst_en, tmo;
  sel_t sel;

  wdt_unlock #(.OPEN_CYCLES(OPEN_CYCLES)) i_unlock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i),
    .is_acc_i (addr_i == ADDR_ACC),
    .data_i   (wdata_i),
    .open_o   (win_open)
  );

  wdt_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_en_i),
    .addr_i     (addr_i),
    .data_i     (wdata_i),
    .win_open_i (win_open),
    .tmo_i      (tmo),
    .restart_o  (restart),
    .sel_o      (sel),
    .rst_en_o   (rst_en),
    .irq_o      (irq_o),
    .rdata_o    (rdata_o)
  );

  wdt_counter #(
    .BASE_SHIFT (BASE_SHIFT),
    .SHIFT_STEP (SHIFT_STEP),
    .WARN_GAP   (WARN_GAP)
  ) i_counter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .sel_i     (sel),
    .rst_en_i  (rst_en),
    .tmo_o     (tmo),
    .rst_req_o (rst_req_o)
  );

  AST_RESTART_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !rst_req_o); // R8
  AST_RST_AFTER_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> rdata_o[BIT_FLAG] || addr_i != ADDR_CTRL || $past(wr_en_i)); // R2
endmodule

// File: tb/test_wdt_timer.sv
module test_wdt_timer;
  localparam int BASE = 4;
  localparam int STEP = 1;
  localparam int GAP  = 8;
  localparam int OPEN = 4;

  localparam logic [7:0] C_RESTART = 8'h01;
  localparam logic [7:0] C_RSTEN   = 8'h02;
  localparam logic [7:0] C_IE      = 8'h04;
  localparam logic [7:0] C_CLR     = 8'h08;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq, rst_req;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  wdt_timer #(
    .BASE_SHIFT (BASE),
    .SHIFT_STEP (STEP),
    .WARN_GAP   (GAP),
    .OPEN_CYCLES(OPEN)
  ) i_wdt_timer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .irq_o     (irq),
    .rst_req_o (rst_req)
  );

  function automatic int len_of(int s);
    return 1 << (BASE + STEP * s);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic unlock();
    wr(2'd1, 8'hAA);
    wr(2'd1, 8'h55);
  endtask

  initial begin
    logic [7:0] v;
    int hits;
    int L;
    step(3);
    rst_n = 1'b1;

    // R11 reset state
    rd(2'd0, v); chk("R11 ctrl", v, 0);
    rd(2'd1, v); chk("R11 acc", v, 0);
    chk("R11 irq", irq, 0);
    chk("R11 rst", rst_req, 0);

    // R1 R2 R9 sweep of all selects
    for (int s = 0; s < 4; s++) begin
      L = len_of(s);
      unlock();
      wr(2'd0, C_RESTART | C_RSTEN | C_IE | C_CLR | 8'(s << 4));
      rd(2'd0, v); chk("R1 readback", v, C_RSTEN | C_IE | 8'(s << 4));
      step(L - 1); chk("R1 early", irq, 0);
      step(1);     chk("R1 timeout", irq, 1);
      step(GAP - 1); chk("R2 early", rst_req, 0);
      step(1);       chk("R2 reset", rst_req, 1);
      step(1);       chk("R9 one cycle", rst_req, 0);
      wr(2'd0, C_RSTEN | C_IE | C_CLR | 8'(s << 4));
      chk("R4 cleared", irq, 0);
      step(L - 3); chk("R9 zero early", irq, 0);
      step(1);     chk("R9 zero period", irq, 1);
    end

    // R7 window length and key order
    unlock();
    rd(2'd1, v); chk("R7 open", v, 1);
    step(OPEN - 1); rd(2'd1, v); chk("R7 last open", v, 1);
    step(1);        rd(2'd1, v); chk("R7 closed", v, 0);
    unlock(); step(OPEN - 1);
    wr(2'd0, C_IE);
    rd(2'd0, v); chk("R7 last cycle write", int'(v[1]), 0);
    unlock(); step(OPEN);
    wr(2'd0, C_RSTEN | C_IE);
    rd(2'd0, v); chk("R7 late write", int'(v[1]), 0);
    wr(2'd1, 8'hAA); wr(2'd0, C_IE); wr(2'd1, 8'h55);
    rd(2'd1, v); chk("R7 broken pair", v, 0);
    wr(2'd1, 8'hAA); step(2); wr(2'd1, 8'h55);
    rd(2'd1, v); chk("R7 idle between", v, 1);
    step(OPEN + 1);
    wr(2'd1, 8'hAB); wr(2'd1, 8'h55);
    rd(2'd1, v); chk("R7 wrong key", v, 0);

    // R6 guarded bits, then R8 restart in guard interval
    unlock();
    wr(2'd0, C_RESTART | C_RSTEN | C_IE | C_CLR);
    step(5);
    wr(2'd0, C_RESTART | C_IE);
    rd(2'd0, v); chk("R6 rst_en kept", int'(v[1]), 1);
    step(9); chk("R6 restart ignored early", irq, 0);
    step(1); chk("R6 restart ignored", irq, 1);
    step(3);
    unlock();
    wr(2'd0, C_RESTART | C_RSTEN | C_IE | C_CLR);
    hits = 0;
    for (int i = 0; i < len_of(0) + GAP - 1; i++) begin
      step(1);
      hits += int'(rst_req);
    end
    chk("R8 no reset", hits, 0);
    step(1); chk("R8 new reset point", rst_req, 1);

    // R3 disarmed: no pulse, counter wraps
    unlock();
    wr(2'd0, C_RESTART | C_IE | C_CLR);
    step(len_of(0) - 1); chk("R3 early", irq, 0);
    step(1);             chk("R3 flag", irq, 1);
    wr(2'd0, C_IE | C_CLR);
    hits = 0;
    for (int i = 0; i < len_of(0) + GAP - 2; i++) begin
      step(1);
      hits += int'(rst_req) + int'(irq);
    end
    chk("R3 quiet", hits, 0);
    step(1); chk("R3 wrap period", irq, 1);

    // R5 enable gating, R4 sticky
    unlock();
    wr(2'd0, C_RESTART | C_CLR);
    step(len_of(0));
    chk("R5 masked", irq, 0);
    rd(2'd0, v); chk("R5 flag set", int'(v[3]), 1);
    step(20);
    rd(2'd0, v); chk("R4 sticky", int'(v[3]), 1);
    wr(2'd0, C_IE); chk("R5 unmasked", irq, 1);
    wr(2'd0, C_IE | C_CLR); chk("R4 clear", irq, 0);

    // R10 select latched at restart
    unlock();
    wr(2'd0, C_RESTART | C_CLR | C_IE);
    wr(2'd0, C_IE | 8'h10);
    rd(2'd0, v); chk("R10 field", int'(v[5:4]), 1);
    step(len_of(0) - 2); chk("R10 old early", irq, 0);
    step(1);             chk("R10 old length", irq, 1);
    unlock();
    wr(2'd0, C_RESTART | C_CLR | C_IE | 8'h10);
    step(len_of(1) - 1); chk("R10 new early", irq, 0);
    step(1);             chk("R10 new length", irq, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule